// File: doc/BRIEF.md
# Stopwatch Interrupt Flag Register

This block holds the interrupt status for a stopwatch timer that produces three periodic tick signals: a 100 Hz tick, a 10 Hz tick and a 1 Hz tick. Each tick input is brought into the local clock domain, and its high-to-low transition is turned into a one-cycle strobe. If the enable for that source is 1 when the strobe occurs, a sticky status flag is set. The flag stays set until software clears it.

Software sees one 8-bit status word on a simple synchronous bus. Reading the word has no side effects. Writing a 1 to a flag bit clears that flag; writing a 0 leaves the bit as it is. The block also drives one level-type request to the interrupt controller. The request is high whenever any flag is set, so the controller should be set to level-triggered mode. Software should clear a stale flag before it sets that source's enable.

Top module: `swt_irq_flags`

## Requirements
- R1: After reset, every bit of `rd_data_o` reads 0 and `irq_o` is 0.
- R2: A 1-to-0 transition on `tick_i[n]` with `enable_i[n]`=1 sets status bit n. Bit 0 is the 100 Hz source, bit 1 is the 10 Hz source and bit 2 is the 1 Hz source. The bit reads 1 after the third rising clock edge that follows the change on the input, and not before.
- R3: A 0-to-1 transition on a tick input, or a tick input held steady, never sets a flag.
- R4: A falling tick does not set the flag if `enable_i[n]` is 0 in the cycle when its internal strobe is active.
- R5: A bus write with `wr_data_i[n]`=1 clears flag n. A bus write with `wr_data_i[n]`=0 leaves flag n unchanged.
- R6: Bits 7 to 3 of `rd_data_o` always read 0, whatever value is written to them.
- R7: `irq_o` is 1 exactly when at least one flag is 1. It rises after the same clock edge that sets the first flag and stays high until the last flag is cleared.
- R8: If a set strobe and a write-one clear reach the same flag on the same clock edge, the flag ends up 1.
- R9: Once a flag is set, changing its enable bit does not change the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 3 | Divided tick inputs (bit 0: 100 Hz, bit 1: 10 Hz, bit 2: 1 Hz) |
| enable_i | input | 3 | Per-source enable bits, from the mask register |
| wr_en_i | input | 1 | Single-cycle write strobe for the status word |
| wr_data_i | input | 8 | Write data; a 1 clears the matching flag |
| rd_data_o | output | 8 | Status word readback |
| irq_o | output | 1 | Level interrupt request toward the interrupt controller |

## Verification
A flag can be set by a tick strobe and cleared by a software write on the same clock edge. The bench creates this collision by lowering a tick and then timing a write of ones so that the write strobe is high on exactly the edge where the strobe lands. It counts the synchronizer and edge-detect register delays to find that edge. After the edge, both the status bit and the request must still read 1. A second write on its own must then clear them.

// File: rtl/swt_flag_pkg.sv
package swt_flag_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned SRC_N = 3;
  typedef logic [REG_W-1:0] status_word_t;
endpackage

// File: rtl/swt_tick_sync.sv
module swt_tick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/swt_fall_det.sv
module swt_fall_det #(
  parameter int unsigned NUM_SRC     = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] tick_i,
  output logic [NUM_SRC-1:0] fall_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic sync_s;
    logic prev_q;

    swt_tick_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (tick_i[g]),
      .q_o   (sync_s)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= sync_s;
    end

    // one-cycle strobe on high-to-low
    assign fall_o[g] = prev_q & ~sync_s;
  end
endmodule

// File: rtl/swt_flag_bank.sv
module swt_flag_bank #(
  parameter int unsigned NUM_SRC = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] flag_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q <= 1'b0;
      else if (set_i[g]) flag_q <= 1'b1;  // set beats clear
      else if (clr_i[g]) flag_q <= 1'b0;
    end
    assign flag_o[g] = flag_q;
  end
endmodule

// File: rtl/swt_rd_fmt.sv
module swt_rd_fmt #(
  parameter int unsigned NUM_SRC = 3,
  parameter int unsigned DATA_W  = 8
) (
  input  logic [NUM_SRC-1:0] flag_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               any_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_SRC;

  assign rd_data_o = {{PAD_W{1'b0}}, flag_i};
  assign any_o     = |flag_i;
endmodule

// File: rtl/swt_irq_flags.sv
module swt_irq_flags
  import swt_flag_pkg::*;
#(
  parameter int unsigned NUM_SRC     = SRC_N,
  parameter int unsigned DATA_W      = REG_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] tick_i,
  input  logic [NUM_SRC-1:0] enable_i,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] fall_s;
  logic [NUM_SRC-1:0] set_s;
  logic [NUM_SRC-1:0] clr_s;
  logic [NUM_SRC-1:0] flag_s;
  logic               unused_wr_hi;

  swt_fall_det #(
    .NUM_SRC    (NUM_SRC),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_fall_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .fall_o(fall_s)
  );

  assign set_s        = fall_s & enable_i;
  assign clr_s        = {NUM_SRC{wr_en_i}} & wr_data_i[NUM_SRC-1:0];
  assign unused_wr_hi = ^wr_data_i[DATA_W-1:NUM_SRC];

  swt_flag_bank #(.NUM_SRC(NUM_SRC)) i_flag_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_s),
    .clr_i (clr_s),
    .flag_o(flag_s)
  );

  swt_rd_fmt #(
    .NUM_SRC(NUM_SRC),
    .DATA_W (DATA_W)
  ) i_rd_fmt (
    .flag_i   (flag_s),
    .rd_data_o(rd_data_o),
    .any_o    (irq_o)
  );
endmodule

// File: rtl/swt_irq_flags_chk.sv
module swt_irq_flags_chk #(
  parameter int unsigned NUM_SRC = 3,
  parameter int unsigned DATA_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] tick_i,
  input logic [NUM_SRC-1:0] enable_i,
  input logic               wr_en_i,
  input logic [DATA_W-1:0]  wr_data_i,
  input logic [DATA_W-1:0]  rd_data_o,
  input logic               irq_o
);
  logic unused_chk_hi;
  assign unused_chk_hi = ^wr_data_i[DATA_W-1:NUM_SRC];

  a_r6_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-1:NUM_SRC] == '0);

  a_r7_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (rd_data_o[NUM_SRC-1:0] != '0));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    a_r2_set_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rd_data_o[g]) |-> (!$past(tick_i[g], 3) && $past(tick_i[g], 4)));

    a_r4_set_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rd_data_o[g]) |-> $past(enable_i[g]));

    a_r5_clear_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rd_data_o[g]) |-> $past(wr_en_i && wr_data_i[g]));

    a_r9_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rd_data_o[g]) && !$past(wr_en_i && wr_data_i[g])) |-> rd_data_o[g]);
  end
endmodule

bind swt_irq_flags swt_irq_flags_chk #(
  .NUM_SRC(NUM_SRC),
  .DATA_W (DATA_W)
) i_swt_irq_flags_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .enable_i (enable_i),
  .wr_en_i  (wr_en_i),
  .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o),
  .irq_o    (irq_o)
);

// File: tb/test_swt_irq_flags.sv
module test_swt_irq_flags;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] tick_i = 3'b000;
  logic [2:0] enable_i = 3'b000;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       irq_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  swt_irq_flags i_swt_irq_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .enable_i (enable_i),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o),
    .irq_o    (irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic bus_write(input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i   = 1'b1;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i   = 1'b0;
    wr_data_i = 8'h00;
  endtask

  // raise a tick, let it settle, then lower it at a negedge
  task automatic drop_tick(input int b);
    @(negedge clk_i);
    tick_i[b] = 1'b1;
    repeat (4) @(negedge clk_i);
    tick_i[b] = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 status after reset", rd_data_o, 8'h00);
    check("R1 irq after reset", irq_o, 1'b0);
  endtask

  task automatic t_set_each;
    enable_i = 3'b111;
    for (int b = 0; b < 3; b++) begin
      drop_tick(b);
      wait_edges(2);
      check("R2 not yet set after two edges", rd_data_o[b], 1'b0);
      wait_edges(1);
      check("R2 flag set after third edge", rd_data_o, 8'h01 << b);
      check("R7 irq with flag", irq_o, 1'b1);
      bus_write(8'h01 << b);
      #1;
      check("R5 write one clears", rd_data_o, 8'h00);
      check("R7 irq drops after clear", irq_o, 1'b0);
    end
  endtask

  task automatic t_rising_only;
    enable_i = 3'b111;
    @(negedge clk_i);
    tick_i = 3'b111;
    wait_edges(6);
    check("R3 rising or steady does not set", rd_data_o, 8'h00);
    @(negedge clk_i);
    tick_i = 3'b000;
    wait_edges(4);
    check("R2 all three set together", rd_data_o, 8'h07);
    bus_write(8'h07);
  endtask

  task automatic t_disabled;
    enable_i = 3'b101;
    drop_tick(1);
    wait_edges(5);
    check("R4 disabled source stays clear", rd_data_o, 8'h00);
    check("R4 irq stays low", irq_o, 1'b0);
    enable_i = 3'b111;
  endtask

  task automatic t_write_zero_and_reserved;
    enable_i = 3'b111;
    drop_tick(0);
    drop_tick(2);
    wait_edges(4);
    check("R2 two flags pending", rd_data_o, 8'h05);
    bus_write(8'hF8);
    #1;
    check("R6 reserved write ignored, high bits zero", rd_data_o, 8'h05);
    bus_write(8'h00);
    #1;
    check("R5 write zero keeps flags", rd_data_o, 8'h05);
    bus_write(8'h01);
    #1;
    check("R5 partial clear", rd_data_o, 8'h04);
    check("R7 irq high while one remains", irq_o, 1'b1);
    bus_write(8'h04);
    #1;
    check("R7 irq low after last clear", irq_o, 1'b0);
  endtask

  task automatic t_collision;
    enable_i = 3'b111;
    drop_tick(1);
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i   = 1'b1;
    wr_data_i = 8'h02;
    wait_edges(1);
    check("R8 set wins over clear", rd_data_o, 8'h02);
    check("R8 irq kept", irq_o, 1'b1);
    @(negedge clk_i);
    wr_en_i   = 1'b0;
    wr_data_i = 8'h00;
    bus_write(8'h02);
    #1;
    check("R5 later clear works", rd_data_o, 8'h00);
  endtask

  task automatic t_enable_drop;
    enable_i = 3'b111;
    drop_tick(2);
    wait_edges(4);
    enable_i = 3'b000;
    wait_edges(3);
    check("R9 flag held after enable drop", rd_data_o, 8'h04);
    check("R9 irq held", irq_o, 1'b1);
    bus_write(8'h04);
    #1;
    check("R5 clear with enable low", rd_data_o, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    rst_ni = 1'b1;
    wait_edges(2);
    t_reset();
    t_set_each();
    t_rising_only();
    t_disabled();
    t_write_zero_and_reserved();
    t_collision();
    t_enable_drop();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule